// File: doc/BRIEF.md
# Shared Gain-Offset Calibration Engine

This block holds the calibration state of a 40-channel converter controller. Each channel has two raw input words (bank A and bank B), a gain word and an offset word. A single global bank bit decides where every data write lands, and which calibrated result is recomputed. A write that changes any input of a calibrated result marks that result as pending.

One multiply-add datapath is time-shared across all channels. It serves the pending results one per clock, in round-robin order. Each finished result is stored in the channel's calibrated A or B register, which the write port cannot reach. The result is also presented for one cycle on a result port for the output stage that follows. A lookup port lets that downstream stage read both calibrated words of any channel.

Top module: `gain_offset_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0, and both calibrated words of every channel read 0x1555 on the lookup port. Raw inputs reset to 0x1555, gain to 0xFFFF and offset to 0x8000.
- R2: A write with `wr_sel`=0 stores `wr_data` into the bank A input when `ab_sel`=0, and into the bank B input when `ab_sel`=1. It recomputes only that bank's result for that channel.
- R3: A write with `wr_sel`=1 (gain) or `wr_sel`=2 (offset) updates the channel's gain or offset word. It recomputes the result of the bank named by `ab_sel` and leaves the other bank's result unchanged.
- R4: A result equals floor(x·(gain+1)/65536) + offset − 32768, where x is the bank's raw input. It is computed from the register values in place after the triggering write.
- R5: A result below 0 is stored as 0, and a result above 65535 is stored as 65535.
- R6: A recalculation produces one `res_valid` pulse carrying bank (`res_bank`: 0=A, 1=B), channel and result, in the cycle after the write. `busy` is high in the cycle the recalculation is being served.
- R7: A write with `wr_sel`=3 or with `wr_chan`≥40 changes no register, and it produces no result and no `busy`.
- R8: The lookup port shows, for `mon_chan`, the last result written to each bank. A channel index of 40 or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_chan | input | 6 | Target channel |
| wr_sel | input | 2 | 0 data, 1 gain, 2 offset, 3 reserved |
| wr_data | input | 16 | Write value |
| ab_sel | input | 1 | Global bank bit |
| busy | output | 1 | A recalculation is pending |
| res_valid | output | 1 | Result strobe |
| res_bank | output | 1 | Bank of the result |
| res_chan | output | 6 | Channel of the result |
| res_data | output | 16 | Calibrated word |
| mon_chan | input | 6 | Lookup channel |
| mon_a | output | 16 | Calibrated bank A word |
| mon_b | output | 16 | Calibrated bank B word |

## Verification
Directed writes use neutral and extreme gain and offset values. These separate a correct floor-and-shift from an off-by-one gain term, and show whether a sum clamps or wraps at either end of the range. Writes of gain and offset under both settings of the bank bit show which result each one recomputes. A long run of back-to-back random writes across random channels, banks and selectors then checks every result strobe against a model, in order. After that run, every stored calibrated word is read back through the lookup port. Reserved selectors and out-of-range channels are mixed in, so any effect they have shows up as an extra strobe or a corrupted later result.

// File: rtl/gain_offset_engine.sv
module gain_offset_engine #(
  parameter int NCH = 40,
  parameter int DW = 16,
  parameter int CW = $clog2(NCH),
  parameter logic [DW-1:0] INIT_X = 16'h1555
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ab_sel,
  output logic          busy,
  output logic          res_valid,
  output logic          res_bank,
  output logic [CW-1:0] res_chan,
  output logic [DW-1:0] res_data,
  input  logic [CW-1:0] mon_chan,
  output logic [DW-1:0] mon_a,
  output logic [DW-1:0] mon_b
);
  localparam int NF = 2 * NCH;
  localparam int FW = $clog2(NF);
  localparam logic [DW-1:0] GAIN0 = '1;
  localparam logic [DW-1:0] OFS0 = DW'(1) << (DW - 1);

  logic [DW-1:0] x1a [NCH];
  logic [DW-1:0] x1b [NCH];
  logic [DW-1:0] gain [NCH];
  logic [DW-1:0] ofs [NCH];
  logic [DW-1:0] cal_a [NCH];
  logic [DW-1:0] cal_b [NCH];
  logic [NF-1:0] pend;
  logic [FW-1:0] ptr;

  wire wr_ok = wr_en && (wr_sel != 2'd3) && (int'(wr_chan) < NCH);

  logic [NF-1:0] set_vec, clr_vec;
  logic          found;
  logic [FW-1:0] pick;
  always_comb begin
    set_vec = '0;
    if (wr_ok) set_vec[FW'(int'(wr_chan) + (ab_sel ? NCH : 0))] = 1'b1;
    found = 1'b0;
    pick = '0;
    for (int j = 0; j < NF; j++) begin
      int idx;
      idx = int'(ptr) + j;
      if (idx >= NF) idx = idx - NF;
      if (!found && pend[FW'(idx)]) begin
        found = 1'b1;
        pick = FW'(idx);
      end
    end
    clr_vec = '0;
    if (found) clr_vec[pick] = 1'b1;
  end

  wire           p_bank = int'(pick) >= NCH;
  wire [CW-1:0]  p_chan = CW'(p_bank ? int'(pick) - NCH : int'(pick));
  wire [DW-1:0]  p_x    = p_bank ? x1b[p_chan] : x1a[p_chan];
  wire [DW:0]    p_g1   = {1'b0, gain[p_chan]} + (DW+1)'(1);
  wire [2*DW:0]  p_prod = {{DW{1'b0}}, p_x} * {{DW{1'b0}}, p_g1};
  wire signed [DW+2:0] p_sum = $signed({3'b000, p_prod[2*DW-1:DW]})
                             + $signed({3'b000, ofs[p_chan]})
                             - $signed({3'b000, OFS0});
  wire [DW-1:0] p_res = p_sum < 0 ? '0 :
                        (p_sum > $signed({3'b000, {DW{1'b1}}}) ? '1 : p_sum[DW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        x1a[i] <= INIT_X;
        x1b[i] <= INIT_X;
        gain[i] <= GAIN0;
        ofs[i] <= OFS0;
        cal_a[i] <= INIT_X;
        cal_b[i] <= INIT_X;
      end
      pend <= '0;
      ptr <= '0;
      res_valid <= 1'b0;
      res_bank <= 1'b0;
      res_chan <= '0;
      res_data <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_sel)
          2'd0: if (ab_sel) x1b[wr_chan] <= wr_data; else x1a[wr_chan] <= wr_data;
          2'd1: gain[wr_chan] <= wr_data;
          default: ofs[wr_chan] <= wr_data;
        endcase
      end
      pend <= (pend & ~clr_vec) | set_vec;
      res_valid <= found;
      if (found) begin
        ptr <= (int'(pick) == NF - 1) ? '0 : pick + FW'(1);
        res_bank <= p_bank;
        res_chan <= p_chan;
        res_data <= p_res;
        if (p_bank) cal_b[p_chan] <= p_res; else cal_a[p_chan] <= p_res;
      end
    end
  end

  assign busy  = |pend;
  assign mon_a = (int'(mon_chan) < NCH) ? cal_a[mon_chan] : '0;
  assign mon_b = (int'(mon_chan) < NCH) ? cal_b[mon_chan] : '0;

  p_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
  p_write_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel != 2'd3 && int'(wr_chan) < NCH |=> busy);
  p_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(wr_en && wr_sel != 2'd3 && int'(wr_chan) < NCH) |=> !busy && !res_valid);
  p_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_bank ? cal_b[res_chan] : cal_a[res_chan]) == res_data);
  p_chan_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> int'(res_chan) < NCH);
endmodule

// File: tb/test_gain_offset_engine.sv
module test_gain_offset_engine;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ab_sel = 0, busy, res_valid, res_bank;
  logic [5:0] wr_chan = 0, res_chan, mon_chan = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0, res_data, mon_a, mon_b;

  gain_offset_engine i_gain_offset_engine (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mx [2][40];
  int mg [40];
  int mo [40];
  int mcal [2][40];
  logic [22:0] expq [$];

  function automatic int calc(int x, int g, int o);
    longint v;
    v = (longint'(x) * longint'(g + 1)) / 65536 + o - 32768;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return int'(v);
  endfunction

  task automatic chk(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(int ch, int sel, int d, bit ab);
    int b, ch_l;
    @(negedge clk);
    wr_en = 1; wr_chan = 6'(ch); wr_sel = 2'(sel); wr_data = 16'(d); ab_sel = ab;
    if (sel != 3 && ch < 40) begin
      b = ab;
      ch_l = ch;
      if (sel == 0) mx[b][ch_l] = d;
      else if (sel == 1) mg[ch_l] = d;
      else mo[ch_l] = d;
      mcal[b][ch_l] = calc(mx[b][ch_l], mg[ch_l], mo[ch_l]);
      expq.push_back({1'(b), 6'(ch_l), 16'(mcal[b][ch_l])});
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    wr_en = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic look(string req, int ch);
    mon_chan = 6'(ch);
    #0.5;
    chk({req, " mon_a"}, mon_a, ch < 40 ? mcal[0][ch] : 0);
    chk({req, " mon_b"}, mon_b, ch < 40 ? mcal[1][ch] : 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (expq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6/R7 unexpected result actual=%0h expected=none", {res_bank, res_chan, res_data});
      end else begin
        logic [22:0] e;
        e = expq.pop_front();
        chk("R4/R6 result", {res_bank, res_chan, res_data}, e);
      end
    end
  end

  task automatic ignored(int ch, int sel);
    @(negedge clk);
    wr_en = 1; wr_chan = 6'(ch); wr_sel = 2'(sel); wr_data = 16'h0;
    @(negedge clk);
    wr_en = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R7 no busy", busy, 0);
      chk("R7 no result", res_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 40; c++) begin
      mx[0][c] = 'h1555; mx[1][c] = 'h1555;
      mg[c] = 'hFFFF; mo[c] = 'h8000;
      mcal[0][c] = 'h1555; mcal[1][c] = 'h1555;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 res_valid", res_valid, 0);
    for (int c = 0; c < 40; c++) look("R1", c);

    wr(3, 0, 'h1234, 0); idle(3); look("R2 bank A", 3);
    wr(3, 0, 'hBEEF, 1); idle(3); look("R2 bank B", 3);
    wr(7, 1, 'h7FFF, 0); idle(3); look("R3 gain A", 7);
    wr(7, 2, 'h9000, 1); idle(3); look("R3 offset B", 7);
    wr(9, 1, 'hFFFF, 0); wr(9, 2, 'hFFFF, 0); wr(9, 0, 'hFFFF, 0); idle(3);
    look("R5 high clamp", 9);
    chk("R5 high value", mon_a, 65535);
    wr(11, 2, 'h0000, 1); wr(11, 0, 'h0010, 1); idle(3);
    look("R5 low clamp", 11);
    chk("R5 low value", mon_b, 0);
    wr(12, 0, 'h0000, 0); idle(3); look("R4 zero input", 12);
    wr(13, 1, 'h0000, 0); wr(13, 0, 'hFFFF, 0); idle(3); look("R4 min gain", 13);
    ignored(5, 3);
    ignored(40, 0);
    ignored(63, 1);
    wr(5, 0, 'h4321, 0); idle(3); look("R7 state untouched", 5);
    look("R8 out of range", 45);

    for (int i = 0; i < 400; i++) begin
      int ch, sel;
      ch = $urandom_range(0, 42);
      sel = $urandom_range(0, 3);
      if (sel == 3 || ch >= 40) begin
        @(negedge clk);
        wr_en = 1; wr_chan = 6'(ch); wr_sel = 2'(sel); wr_data = 16'($urandom); ab_sel = 1'($urandom);
      end else wr(ch, sel, int'($urandom_range(0, 65535)), 1'($urandom));
    end
    idle(4);
    chk("R6 drained", busy, 0);
    chk("R6 queue empty", expq.size(), 0);
    for (int c = 0; c < 40; c++) look("R8 final", c);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule